// File: doc/BRIEF.md
# Center-of-Gravity Defuzzifier

This block turns rule activations into crisp controller outputs. Each consequent membership function (MF) is held in a small parameter RAM as two 8-bit numbers: its area and its barycentre. An upstream inference stage streams activation beats. Each beat names an MF and carries its activation level (alpha). The block accumulates sum(alpha*area*barycentre) and sum(alpha*area) for the current output variable. When the beat that closes the variable arrives, it divides the first sum by the second with a sequential restoring divider. The result is an 8-bit crisp value.

Results appear one variable at a time on a shared output bus. Each result comes with a one-cycle strobe and a 4-bit counter that names the output variable. The beat that closes a variable can also close the whole processing cycle. In that case a one-cycle end flag follows the final result and the variable counter restarts at zero. A host loads the parameter RAM through a simple write port before on-line use. The upstream stage is paused through `act_ready` while a division is in flight.

Top module: `cog_defuzzifier`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_strobe`, `out_done`, `out_data` and `out_var` are 0 and `act_ready` is 1.
- R2: For each output variable, `out_data` equals floor(sum(alpha*area*bary) / sum(alpha*area)), taken over the beats accepted for that variable. It is presented with `out_strobe` high for exactly one clock.
- R3: If sum(alpha*area) for a variable is zero, `out_data` is 0 and `out_strobe` is still issued.
- R4: `out_var` gives the index of the variable in the current cycle. It is 0 for the first result after reset or after an end flag, and it increases by one for each later result.
- R5: `out_done` is high for exactly one clock, in the cycle after the strobe of the variable whose closing beat had `act_end_cycle` set. It is not raised after any other strobe.
- R6: A beat is accepted at a rising edge where `act_valid` and `act_ready` are both high. After a closing beat (`act_end_var` high) is accepted, `act_ready` stays low and `out_strobe` stays low for the next 8 cycles. The strobe appears in the 9th cycle, and `act_ready` returns high in that same cycle.
- R7: A host write (`cfg_we` high at a rising edge) stores `cfg_area` and `cfg_bary` at index `cfg_addr`. The stored values are used by all beats accepted afterwards.
- R8: The accumulated sums start from zero for every variable, so a result depends only on that variable's own beats.
- R9: A beat with alpha 0 does not change the result.
- R10: `out_data` and `out_var` hold their values in every cycle in which `out_strobe` is low.
- R11: Up to 128 beats per variable, each with alpha, area and barycentre at 255, accumulate without overflow. The result stays exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write enable for the MF parameter RAM |
| cfg_addr | input | 7 | MF index to write |
| cfg_area | input | 8 | Area of the MF being written |
| cfg_bary | input | 8 | Barycentre of the MF being written |
| act_valid | input | 1 | Activation beat present |
| act_ready | output | 1 | Block can take a beat this cycle |
| act_mf | input | 7 | MF index of the beat |
| act_alpha | input | 8 | Activation level of the beat |
| act_end_var | input | 1 | Beat closes the current output variable |
| act_end_cycle | input | 1 | With `act_end_var`, beat also closes the processing cycle |
| out_data | output | 8 | Crisp output value |
| out_var | output | 4 | Index of the variable on `out_data` |
| out_strobe | output | 1 | One-cycle result-ready pulse |
| out_done | output | 1 | One-cycle end-of-process pulse |

## Verification
The ratio is exercised with a two-MF mix whose result lies strictly between the barycentres. A single-MF variable must return exactly its own barycentre, which also shows that the sums were cleared since the previous variable. A variable made only of zero-area or zero-alpha beats gives the divide-by-zero case. A beat with alpha 0 next to a live one must leave the live barycentre untouched. Rewriting an MF and repeating an earlier stimulus separates live RAM reads from stale values. A 128-beat variable at full scale and an alternating full/zero barycentre run (true centroid 127.5) probe accumulator width and divider truncation. Every result is also timed against the fixed ready and strobe window, and the end flag is checked against final and non-final variables.

// File: rtl/cog_pkg.sv
// Package: shared types for the center-of-gravity defuzzifier.
// Assumes nothing beyond standard SystemVerilog.
package cog_pkg;

    // Divider sequencing state.
    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/cog_param_ram.sv
// Module: consequent MF parameter store.
// Holds one {area, barycentre} pair per MF. There is one write port for the
// host and one registered read port for the datapath.
// Assumes the host does not write an entry while that entry is being read.
module cog_param_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_area,
    input  logic [DATA_W-1:0] wr_bary,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_area,
    output logic [DATA_W-1:0] rd_bary
);

    logic [2*DATA_W-1:0] mem [DEPTH];

    // Host write into the array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= {wr_area, wr_bary};
        end
    end

    // Registered read; the output holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_area <= '0;
            rd_bary <= '0;
        end else if (rd_en) begin
            rd_area <= mem[rd_addr][2*DATA_W-1:DATA_W];
            rd_bary <= mem[rd_addr][DATA_W-1:0];
        end
    end

endmodule

// File: rtl/cog_mac.sv
// Module: weighted-sum accumulator.
// Adds alpha*area*bary into the numerator and alpha*area into the denominator.
// The totals include the current beat and are offered combinationally.
// Both sums are cleared after a closing beat.
// Assumes at most 2**CNT_W beats per variable, which sets the widths.
module cog_mac #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7,
    localparam int NUM_W = 3*DATA_W + CNT_W,
    localparam int DEN_W = 2*DATA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] alpha,
    input  logic [DATA_W-1:0] area,
    input  logic [DATA_W-1:0] bary,
    output logic [NUM_W-1:0]  num_total,
    output logic [DEN_W-1:0]  den_total
);

    logic [NUM_W-1:0]    num_acc;
    logic [DEN_W-1:0]    den_acc;
    logic [2*DATA_W-1:0] weight;
    logic [3*DATA_W-1:0] moment;

    // Per-beat weight and moment terms.
    always_comb begin
        weight    = alpha * area;
        moment    = weight * bary;
        num_total = num_acc + (in_valid ? NUM_W'(moment) : '0);
        den_total = den_acc + (in_valid ? DEN_W'(weight) : '0);
    end

    // Accumulate beats; restart from zero after a closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_acc <= '0;
            den_acc <= '0;
        end else if (in_valid) begin
            num_acc <= in_last ? '0 : num_total;
            den_acc <= in_last ? '0 : den_total;
        end
    end

    // R2: the numerator never exceeds the denominator times the largest barycentre.
    a_r2_num_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_W+DATA_W)'(num_acc) <= (NUM_W+DATA_W)'(den_acc) * ((NUM_W+DATA_W)'(1) << DATA_W));

endmodule

// File: rtl/cog_divider.sv
// Module: sequential restoring divider.
// Produces QW quotient bits, one per clock, from the most significant down.
// Assumes num < den * 2**QW. This holds because every barycentre is below
// 2**QW. A zero divisor gives a zero quotient.
module cog_divider
    import cog_pkg::*;
#(
    parameter int NUM_W = 31,
    parameter int DEN_W = 23,
    parameter int QW    = 8,
    localparam int CW   = $clog2(QW+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             last_step,
    output logic [QW-1:0]    quot,
    output logic             quot_valid
);

    div_state_e       state;
    logic [NUM_W-1:0] rem_q;
    logic [NUM_W-1:0] dsh_q;
    logic [QW-1:0]    quo_q;
    logic [CW-1:0]    cnt_q;
    logic             zero_q;
    logic             fits;
    logic [QW-1:0]    quo_nxt;

    // One restoring step: compare, then shift in the quotient bit.
    always_comb begin
        fits      = rem_q >= dsh_q;
        quo_nxt   = {quo_q[QW-2:0], fits};
        busy      = (state == DV_RUN);
        last_step = busy && (cnt_q == CW'(1));
    end

    // Load operands on start, then iterate QW times and publish the quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= DV_IDLE;
            rem_q      <= '0;
            dsh_q      <= '0;
            quo_q      <= '0;
            cnt_q      <= '0;
            zero_q     <= 1'b0;
            quot       <= '0;
            quot_valid <= 1'b0;
        end else begin
            quot_valid <= 1'b0;
            if (start) begin
                state  <= DV_RUN;
                rem_q  <= num;
                dsh_q  <= NUM_W'(den) << (QW-1);
                quo_q  <= '0;
                cnt_q  <= CW'(QW);
                zero_q <= (den == '0);
            end else if (busy) begin
                if (fits) begin
                    rem_q <= rem_q - dsh_q;
                end
                dsh_q <= dsh_q >> 1;
                quo_q <= quo_nxt;
                cnt_q <= cnt_q - CW'(1);
                if (last_step) begin
                    state      <= DV_IDLE;
                    quot       <= zero_q ? '0 : quo_nxt;
                    quot_valid <= 1'b1;
                end
            end
        end
    end

    // R6: a new division is never launched over one in progress.
    a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R2: the operands handed over keep the quotient within QW bits.
    a_r2_quot_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (start && den != '0) |-> ((NUM_W+1)'(num) < ((NUM_W+1)'(den) << QW)));

endmodule

// File: rtl/cog_defuzzifier.sv
// Module: center-of-gravity defuzzifier top.
// Takes activation beats, looks up each MF's area and barycentre, accumulates
// the weighted sums, then divides to give one crisp value per output variable.
// Each value is tagged with a variable index and a strobe. An end flag follows
// the final variable of a cycle.
// Assumes the upstream stage respects act_ready and sends at most N_MF beats
// per variable.
module cog_defuzzifier #(
    parameter int DATA_W = 8,
    parameter int N_MF   = 128,
    parameter int N_VAR  = 16,
    localparam int MF_AW = $clog2(N_MF),
    localparam int VAR_W = $clog2(N_VAR),
    localparam int NUM_W = 3*DATA_W + MF_AW,
    localparam int DEN_W = 2*DATA_W + MF_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MF_AW-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_area,
    input  logic [DATA_W-1:0] cfg_bary,
    input  logic              act_valid,
    output logic              act_ready,
    input  logic [MF_AW-1:0]  act_mf,
    input  logic [DATA_W-1:0] act_alpha,
    input  logic              act_end_var,
    input  logic              act_end_cycle,
    output logic [DATA_W-1:0] out_data,
    output logic [VAR_W-1:0]  out_var,
    output logic              out_strobe,
    output logic              out_done
);

    logic              accept;
    logic              s1_valid;
    logic              s1_end_var;
    logic              s1_end_cycle;
    logic [DATA_W-1:0] s1_alpha;
    logic [DATA_W-1:0] mf_area;
    logic [DATA_W-1:0] mf_bary;
    logic [NUM_W-1:0]  num_total;
    logic [DEN_W-1:0]  den_total;
    logic              div_start;
    logic              div_busy;
    logic              div_last;
    logic [VAR_W-1:0]  var_cnt;
    logic [VAR_W-1:0]  job_var;
    logic              job_final;
    logic              out_final;

    // Handshake: stall while a closing beat waits or a division runs.
    always_comb begin
        act_ready = !(s1_valid && s1_end_var) && !div_busy;
        accept    = act_valid && act_ready;
        div_start = s1_valid && s1_end_var;
    end

    // Stage 1: hold the beat while its MF parameters are read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid     <= 1'b0;
            s1_alpha     <= '0;
            s1_end_var   <= 1'b0;
            s1_end_cycle <= 1'b0;
        end else begin
            s1_valid     <= accept;
            s1_alpha     <= act_alpha;
            s1_end_var   <= act_end_var;
            s1_end_cycle <= act_end_var && act_end_cycle;
        end
    end

    cog_param_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (N_MF)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_area (cfg_area),
        .wr_bary (cfg_bary),
        .rd_en   (accept),
        .rd_addr (act_mf),
        .rd_area (mf_area),
        .rd_bary (mf_bary)
    );

    cog_mac #(
        .DATA_W (DATA_W),
        .CNT_W  (MF_AW)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .in_last   (s1_end_var),
        .alpha     (s1_alpha),
        .area      (mf_area),
        .bary      (mf_bary),
        .num_total (num_total),
        .den_total (den_total)
    );

    cog_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W),
        .QW    (DATA_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (div_start),
        .num        (num_total),
        .den        (den_total),
        .busy       (div_busy),
        .last_step  (div_last),
        .quot       (out_data),
        .quot_valid (out_strobe)
    );

    // Variable numbering: tag each division and advance or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            var_cnt   <= '0;
            job_var   <= '0;
            job_final <= 1'b0;
        end else if (div_start) begin
            job_var   <= var_cnt;
            job_final <= s1_end_cycle;
            var_cnt   <= s1_end_cycle ? '0 : var_cnt + VAR_W'(1);
        end
    end

    // Output tagging: publish the index with the quotient; end flag one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_var   <= '0;
            out_final <= 1'b0;
            out_done  <= 1'b0;
        end else begin
            if (div_last) begin
                out_var   <= job_var;
                out_final <= job_final;
            end
            out_done <= out_strobe && out_final;
        end
    end

    // R6: no beat is taken while the divider works.
    a_r6_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !act_ready);

    // R2: the result strobe is one clock wide.
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

    // R5: the end flag only ever directly follows a strobe.
    a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(out_strobe));

    // R4: numbering has restarted by the time the end flag shows.
    a_r4_count_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (var_cnt == '0));

    // R10: published value and index stay put between strobes.
    a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !out_strobe |-> ($stable(out_data) && $stable(out_var)));

endmodule

// File: tb/sim_cog_defuzzifier.sv
module sim_cog_defuzzifier;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [6:0] cfg_addr;
    logic [7:0] cfg_area;
    logic [7:0] cfg_bary;
    logic       act_valid;
    logic       act_ready;
    logic [6:0] act_mf;
    logic [7:0] act_alpha;
    logic       act_end_var;
    logic       act_end_cycle;
    logic [7:0] out_data;
    logic [3:0] out_var;
    logic       out_strobe;
    logic       out_done;

    int n_checks = 0;
    int n_fail   = 0;
    int sh_area [128];
    int sh_bary [128];
    int bm [256];
    int ba [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    cog_defuzzifier u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_area      (cfg_area),
        .cfg_bary      (cfg_bary),
        .act_valid     (act_valid),
        .act_ready     (act_ready),
        .act_mf        (act_mf),
        .act_alpha     (act_alpha),
        .act_end_var   (act_end_var),
        .act_end_cycle (act_end_cycle),
        .out_data      (out_data),
        .out_var       (out_var),
        .out_strobe    (out_strobe),
        .out_done      (out_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_mf(input int idx, input int area, input int bary);
        cfg_we   = 1'b1;
        cfg_addr = 7'(idx);
        cfg_area = 8'(area);
        cfg_bary = 8'(bary);
        sh_area[idx] = area;
        sh_bary[idx] = bary;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_beat(input int mf, input int alpha, input bit last, input bit fin);
        while (!act_ready) @(negedge clk);
        act_valid     = 1'b1;
        act_mf        = 7'(mf);
        act_alpha     = 8'(alpha);
        act_end_var   = last;
        act_end_cycle = fin;
        @(negedge clk);
        act_valid     = 1'b0;
        act_end_var   = 1'b0;
        act_end_cycle = 1'b0;
    endtask

    function automatic int model(input int n);
        longint num = 0;
        longint den = 0;
        for (int i = 0; i < n; i++) begin
            num += longint'(ba[i]) * sh_area[bm[i]] * sh_bary[bm[i]];
            den += longint'(ba[i]) * sh_area[bm[i]];
        end
        return (den == 0) ? 0 : int'(num / den);
    endfunction

    // Sends one variable's beats and checks timing, value, index and end flag.
    task automatic run_var(input int n, input bit fin, input int exp_var, input string req);
        int  exp;
        int  prev;
        bit  quiet;
        bit  held;
        exp = model(n);
        for (int i = 0; i < n; i++) begin
            send_beat(bm[i], ba[i], i == n-1, fin && (i == n-1));
        end
        prev  = int'(out_data);
        quiet = 1'b1;
        held  = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (out_strobe || act_ready) quiet = 1'b0;
            if (int'(out_data) != prev) held = 1'b0;
        end
        check(quiet, "R6 ready/strobe low during divide", int'(quiet), 1);
        check(held, "R10 out_data held while dividing", int'(out_data), prev);
        @(negedge clk);
        check(out_strobe == 1'b1, "R6 strobe in 9th cycle", int'(out_strobe), 1);
        check(act_ready == 1'b1, "R6 ready back with strobe", int'(act_ready), 1);
        check(int'(out_data) == exp, req, int'(out_data), exp);
        check(int'(out_var) == exp_var, "R4 variable index", int'(out_var), exp_var);
        prev = int'(out_data);
        @(negedge clk);
        check(out_strobe == 1'b0, "R2 strobe one clock wide", int'(out_strobe), 0);
        check(out_done == fin, "R5 end flag after strobe", int'(out_done), int'(fin));
        check(int'(out_data) == prev && int'(out_var) == exp_var,
              "R10 outputs held after strobe", int'(out_data), prev);
        if (fin) begin
            @(negedge clk);
            check(out_done == 1'b0, "R5 end flag one clock", int'(out_done), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_area = '0; cfg_bary = '0;
        act_valid = 1'b0; act_mf = '0; act_alpha = '0;
        act_end_var = 1'b0; act_end_cycle = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_strobe && !out_done, "R1 flags low in reset", int'(out_strobe), 0);
        check(out_data == 0 && out_var == 0, "R1 outputs zero in reset", int'(out_data), 0);
        check(act_ready == 1'b1, "R1 ready in reset", int'(act_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_strobe && !out_done && act_ready, "R1 state after release", int'(out_strobe), 0);
    endtask

    task automatic t_load();
        write_mf(0, 10, 50);
        write_mf(1, 20, 200);
        write_mf(2, 255, 255);
        write_mf(3, 0, 100);
        write_mf(4, 255, 0);
    endtask

    // Three variables in one cycle: mixed, single MF, zero weight.
    task automatic t_cycle3();
        bm[0] = 0; ba[0] = 100; bm[1] = 1; ba[1] = 50;
        run_var(2, 1'b0, 0, "R2 two-MF centroid");
        bm[0] = 2; ba[0] = 255;
        run_var(1, 1'b0, 1, "R8 sums cleared, single MF");
        bm[0] = 3; ba[0] = 200; bm[1] = 0; ba[1] = 0;
        run_var(2, 1'b1, 2, "R3 zero denominator gives 0");
    endtask

    task automatic t_alpha_zero();
        bm[0] = 0; ba[0] = 0; bm[1] = 1; ba[1] = 77;
        run_var(2, 1'b1, 0, "R9 zero-alpha beat ignored");
    endtask

    task automatic t_rewrite();
        write_mf(1, 30, 20);
        bm[0] = 0; ba[0] = 100; bm[1] = 1; ba[1] = 50;
        run_var(2, 1'b1, 0, "R7 rewritten MF used");
    endtask

    task automatic t_full_scale();
        for (int i = 0; i < 128; i++) begin
            bm[i] = 2; ba[i] = 255;
        end
        run_var(128, 1'b0, 0, "R11 full-scale 128 beats");
        for (int i = 0; i < 128; i++) begin
            bm[i] = (i % 2 == 0) ? 2 : 4; ba[i] = 255;
        end
        run_var(128, 1'b1, 1, "R11 wide sums truncated to 127");
    endtask

    initial begin
        t_reset();
        t_load();
        t_cycle3();
        t_alpha_zero();
        t_rewrite();
        t_full_scale();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule